// File: doc/BRIEF.md
# Command Decoder with Keyed Write Locks

This block sits behind a serial-peripheral receiver. Each decoded frame delivers a command byte and a data byte together with a one-cycle valid strobe. The block turns each frame into one of four things: a register read, a register write, a keyed one-shot action, or nothing. It decides whether a write may proceed from three software lock flags and a device-state input. Writes leave through a register-file write port that carries an index, data and a bit mask. Reads return through a registered read-data output, selected from the register-file values presented at the input.

The lock flags are controlled by commands that only take effect with the correct key byte:

- A control lock guards the control registers.
- A self-test lock is held for the self-test logic.
- A configuration lock, together with a diagnostic-state input, guards the configuration registers and one status sub-field.

A write that is refused, and a keyed command sent with the wrong key, each set a sticky flag. Software can read these flags through a status command. Raising the device-reset input returns every flag to its default.

Top module: `cmdg_top`

## Requirements
- R1: While `rst_n` is low, or in the cycle after `in_reset` was high, all three lock flags, auto-start-disable and both sticky flags are 0. No write or pulse is issued, and `rd_data` is 0. A frame presented while `in_reset` is high has no effect.
- R2: The lock commands take effect only with their key:
  - control lock: set by command 0xC1 with data 0x55, cleared by 0xC2 with data 0xAA;
  - self-test lock: set by 0xF1/0x55, cleared by 0xF2/0xAA;
  - configuration lock: set by 0xC4/0x55, cleared by 0xC7/0xAA.
- R3: Command 0x58 returns a status byte with these bits:
  - bit0: control lock;
  - bit1: self-test lock;
  - bit2: configuration lock;
  - bit3: auto-start-disable;
  - bit4: write-rejected;
  - bit5: command-error;
  - bits 7:6: 0.
- R4: Configuration writes are issued only while the configuration lock is clear and `in_diag` is 1. These are 0xFB (index 0, read back with 0x0B) and 0xFD (index 1, read back with 0x0D).
- R5: Control writes are issued only while the control lock is clear, in any device state. These are 0xD8 (index 2, read with 0x28) and 0xDD (index 3, read with 0x2D).
- R6: Self-test writes are issued whatever the locks and state. These are 0xAB (index 4, read with 0x5B) and 0xAD (index 5, read with 0x5D).
- R7: Command 0xA4 writes index 6 (read with 0x52) with mask 0x0F, under the same gate as R4. Every other write uses mask 0xFF.
- R8: A write refused by a lock or by the device state issues no write strobe and sets the sticky write-rejected flag.
- R9: Two keyed commands each raise a one-cycle pulse: 0xF8 with data 0x5A raises `rst_req`, and 0xDE with data 0x8E raises `wake_clr`.
- R10: Command 0xF4 with data 0x55 clears `auto_start_dis`, and 0xF7 with data 0xAA sets it.
- R11: A keyed command sent with any other data byte changes no lock or bit and raises no pulse. It sets the sticky command-error flag.
- R12: Command 0x02 returns register index 7. An unrecognised command returns 0x00 and performs no action.
- R13: All outputs change at the clock edge that samples the frame. The write strobe and the pulses last exactly one cycle, and `rd_data` holds its value until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_reset | input | 1 | Device is in its reset state; returns flags to defaults |
| in_diag | input | 1 | Device is in its diagnostic state |
| frm_valid | input | 1 | One-cycle strobe for a decoded frame |
| frm_cmd | input | 8 | Command byte |
| frm_data | input | 8 | Data or key byte |
| rf_val | input | 64 | Current values of the eight registers, byte n at bits 8n+7:8n |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | 3 | Register index for the write |
| reg_wdata | output | 8 | Write data |
| reg_wmask | output | 8 | Bits of the register that the write updates |
| rd_data | output | 8 | Response byte of the last frame |
| rst_req | output | 1 | Reset request pulse |
| wake_clr | output | 1 | Wake-latch clear pulse |
| auto_start_dis | output | 1 | Auto-start-disable bit |

## Verification
The assertions assume that `frm_valid` is a clean strobe. They also assume that `in_diag` and the lock state seen at the sampling edge are the ones that gate the frame. They relate each write strobe, and each index it targets, to the lock and state values one cycle earlier. The bench drives each frame for exactly one cycle and holds `in_diag` steady across it. It leaves idle cycles between frames, so register-file updates settle before any read that depends on them. The bench drives the reset input only between frames, except in one deliberate case that checks a frame is ignored during reset.

// File: rtl/cmdg_pkg.sv
package cmdg_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_N  = 8;
    localparam int IDX_W  = $clog2(REG_N);

    localparam logic [BYTE_W-1:0] KEY_ON   = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_OFF  = 8'hAA;
    localparam logic [BYTE_W-1:0] KEY_RST  = 8'h5A;
    localparam logic [BYTE_W-1:0] KEY_WAKE = 8'h8E;
    localparam logic [BYTE_W-1:0] MASK_FC  = 8'h0F;

    localparam logic [IDX_W-1:0] RI_CFG_A = 3'd0;
    localparam logic [IDX_W-1:0] RI_CFG_B = 3'd1;
    localparam logic [IDX_W-1:0] RI_PWR   = 3'd2;
    localparam logic [IDX_W-1:0] RI_CLK   = 3'd3;
    localparam logic [IDX_W-1:0] RI_TST_A = 3'd4;
    localparam logic [IDX_W-1:0] RI_TST_B = 3'd5;
    localparam logic [IDX_W-1:0] RI_FCNT  = 3'd6;
    localparam logic [IDX_W-1:0] RI_ID    = 3'd7;

    localparam int SB_CTRL = 0;
    localparam int SB_TST  = 1;
    localparam int SB_CFG  = 2;
    localparam int SB_AS   = 3;
    localparam int SB_REJ  = 4;
    localparam int SB_ERR  = 5;

    typedef enum logic [2:0] {K_NONE, K_READ, K_WRITE, K_KEYED, K_STATUS} kind_e;
    typedef enum logic [1:0] {G_OPEN, G_CTRL, G_CFG} grp_e;
    typedef enum logic [3:0] {
        A_NONE, A_CTRL_SET, A_CTRL_CLR, A_TST_SET, A_TST_CLR, A_CFG_SET,
        A_CFG_CLR, A_WAKE, A_RST, A_AS_CLR, A_AS_SET
    } act_e;

    typedef struct packed {
        kind_e             kind;
        grp_e              grp;
        act_e              act;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] key;
        logic [BYTE_W-1:0] mask;
    } dec_t;
endpackage

// File: rtl/cmdg_decode.sv
module cmdg_decode
    import cmdg_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd,
    output dec_t              dec
);
    always_comb begin
        dec.kind = K_NONE;
        dec.grp  = G_OPEN;
        dec.act  = A_NONE;
        dec.idx  = '0;
        dec.key  = '0;
        dec.mask = '1;
        case (cmd)
            8'hC1: begin dec.kind = K_KEYED; dec.act = A_CTRL_SET; dec.key = KEY_ON;   end
            8'hC2: begin dec.kind = K_KEYED; dec.act = A_CTRL_CLR; dec.key = KEY_OFF;  end
            8'hF1: begin dec.kind = K_KEYED; dec.act = A_TST_SET;  dec.key = KEY_ON;   end
            8'hF2: begin dec.kind = K_KEYED; dec.act = A_TST_CLR;  dec.key = KEY_OFF;  end
            8'hC4: begin dec.kind = K_KEYED; dec.act = A_CFG_SET;  dec.key = KEY_ON;   end
            8'hC7: begin dec.kind = K_KEYED; dec.act = A_CFG_CLR;  dec.key = KEY_OFF;  end
            8'hDE: begin dec.kind = K_KEYED; dec.act = A_WAKE;     dec.key = KEY_WAKE; end
            8'hF8: begin dec.kind = K_KEYED; dec.act = A_RST;      dec.key = KEY_RST;  end
            8'hF4: begin dec.kind = K_KEYED; dec.act = A_AS_CLR;   dec.key = KEY_ON;   end
            8'hF7: begin dec.kind = K_KEYED; dec.act = A_AS_SET;   dec.key = KEY_OFF;  end
            8'hFB: begin dec.kind = K_WRITE; dec.grp = G_CFG;  dec.idx = RI_CFG_A; end
            8'hFD: begin dec.kind = K_WRITE; dec.grp = G_CFG;  dec.idx = RI_CFG_B; end
            8'hD8: begin dec.kind = K_WRITE; dec.grp = G_CTRL; dec.idx = RI_PWR;   end
            8'hDD: begin dec.kind = K_WRITE; dec.grp = G_CTRL; dec.idx = RI_CLK;   end
            8'hAB: begin dec.kind = K_WRITE; dec.idx = RI_TST_A; end
            8'hAD: begin dec.kind = K_WRITE; dec.idx = RI_TST_B; end
            8'hA4: begin dec.kind = K_WRITE; dec.grp = G_CFG; dec.idx = RI_FCNT; dec.mask = MASK_FC; end
            8'h0B: begin dec.kind = K_READ; dec.idx = RI_CFG_A; end
            8'h0D: begin dec.kind = K_READ; dec.idx = RI_CFG_B; end
            8'h28: begin dec.kind = K_READ; dec.idx = RI_PWR;   end
            8'h2D: begin dec.kind = K_READ; dec.idx = RI_CLK;   end
            8'h5B: begin dec.kind = K_READ; dec.idx = RI_TST_A; end
            8'h5D: begin dec.kind = K_READ; dec.idx = RI_TST_B; end
            8'h52: begin dec.kind = K_READ; dec.idx = RI_FCNT;  end
            8'h02: begin dec.kind = K_READ; dec.idx = RI_ID;    end
            8'h58: dec.kind = K_STATUS;
            default: ;
        endcase
    end
endmodule

// File: rtl/cmdg_locks.sv
module cmdg_locks
    import cmdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fire,
    input  act_e              act,
    input  logic              key_bad,
    input  logic              wr_blocked,
    output logic [BYTE_W-1:0] status,
    output logic              ctrl_lock,
    output logic              cfg_lock,
    output logic              as_dis
);
    typedef struct packed {
        logic ctrl;
        logic tst;
        logic cfg;
        logic as;
        logic rej;
        logic err;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (clr) begin
            lk_d = '0;
        end else begin
            if (fire) begin
                case (act)
                    A_CTRL_SET: lk_d.ctrl = 1'b1;
                    A_CTRL_CLR: lk_d.ctrl = 1'b0;
                    A_TST_SET:  lk_d.tst  = 1'b1;
                    A_TST_CLR:  lk_d.tst  = 1'b0;
                    A_CFG_SET:  lk_d.cfg  = 1'b1;
                    A_CFG_CLR:  lk_d.cfg  = 1'b0;
                    A_AS_SET:   lk_d.as   = 1'b1;
                    A_AS_CLR:   lk_d.as   = 1'b0;
                    default: ;
                endcase
            end
            if (key_bad)    lk_d.err = 1'b1;
            if (wr_blocked) lk_d.rej = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    always_comb begin
        status         = '0;
        status[SB_CTRL] = lk_q.ctrl;
        status[SB_TST]  = lk_q.tst;
        status[SB_CFG]  = lk_q.cfg;
        status[SB_AS]   = lk_q.as;
        status[SB_REJ]  = lk_q.rej;
        status[SB_ERR]  = lk_q.err;
    end

    assign ctrl_lock = lk_q.ctrl;
    assign cfg_lock  = lk_q.cfg;
    assign as_dis    = lk_q.as;

    // R1: a device reset leaves every flag at zero
    a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status == '0));
    // R2: the control lock only rises on its keyed set command
    a_r2_ctrl_rise_keyed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_lock) |-> $past(fire && act == A_CTRL_SET));
    // R11: the command-error flag stays set until a device reset
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[SB_ERR] && !clr) |=> status[SB_ERR]);
endmodule

// File: rtl/cmdg_top.sv
module cmdg_top
    import cmdg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_reset,
    input  logic                         in_diag,
    input  logic                         frm_valid,
    input  logic [BYTE_W-1:0]            frm_cmd,
    input  logic [BYTE_W-1:0]            frm_data,
    input  logic [REG_N-1:0][BYTE_W-1:0] rf_val,
    output logic                         reg_we,
    output logic [IDX_W-1:0]             reg_idx,
    output logic [BYTE_W-1:0]            reg_wdata,
    output logic [BYTE_W-1:0]            reg_wmask,
    output logic [BYTE_W-1:0]            rd_data,
    output logic                         rst_req,
    output logic                         wake_clr,
    output logic                         auto_start_dis
);
    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] wdata;
        logic [BYTE_W-1:0] wmask;
        logic [BYTE_W-1:0] rd;
        logic              rst;
        logic              wake;
    } out_t;

    dec_t              dec;
    logic              live, keyed, fire, key_bad, is_wr, allow, blocked;
    logic              ctrl_lock, cfg_lock;
    logic [BYTE_W-1:0] status;
    out_t              o_d, o_q;

    cmdg_decode u_dec (.cmd(frm_cmd), .dec(dec));

    always_comb begin
        live    = frm_valid && !in_reset;
        keyed   = live && (dec.kind == K_KEYED);
        fire    = keyed && (frm_data == dec.key);
        key_bad = keyed && (frm_data != dec.key);
        is_wr   = live && (dec.kind == K_WRITE);
        case (dec.grp)
            G_CTRL:  allow = !ctrl_lock;
            G_CFG:   allow = !cfg_lock && in_diag;
            default: allow = 1'b1;
        endcase
        blocked = is_wr && !allow;
    end

    cmdg_locks u_locks (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (in_reset),
        .fire       (fire),
        .act        (dec.act),
        .key_bad    (key_bad),
        .wr_blocked (blocked),
        .status     (status),
        .ctrl_lock  (ctrl_lock),
        .cfg_lock   (cfg_lock),
        .as_dis     (auto_start_dis)
    );

    always_comb begin
        o_d    = '0;
        o_d.rd = in_reset ? '0 : o_q.rd;
        if (live) begin
            case (dec.kind)
                K_READ:   o_d.rd = rf_val[dec.idx];
                K_STATUS: o_d.rd = status;
                default:  o_d.rd = '0;
            endcase
            if (is_wr && allow) begin
                o_d.we    = 1'b1;
                o_d.idx   = dec.idx;
                o_d.wdata = frm_data;
                o_d.wmask = dec.mask;
            end
            o_d.rst  = fire && (dec.act == A_RST);
            o_d.wake = fire && (dec.act == A_WAKE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign reg_we    = o_q.we;
    assign reg_idx   = o_q.idx;
    assign reg_wdata = o_q.wdata;
    assign reg_wmask = o_q.wmask;
    assign rd_data   = o_q.rd;
    assign rst_req   = o_q.rst;
    assign wake_clr  = o_q.wake;

    // R4: configuration-guarded writes only leave in the diagnostic state with the lock clear
    a_r4_cfg_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_idx == RI_CFG_A || reg_idx == RI_CFG_B || reg_idx == RI_FCNT))
        |-> ($past(in_diag) && !$past(cfg_lock)));
    // R5: control writes never leave while the control lock is set
    a_r5_ctrl_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_idx == RI_PWR || reg_idx == RI_CLK)) |-> !$past(ctrl_lock));
    // R7: the fail-count write touches only the low nibble
    a_r7_fc_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == RI_FCNT) |-> (reg_wmask == MASK_FC));
    // R9: one frame yields at most one of write, reset request and wake clear
    a_r9_one_effect: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, rst_req, wake_clr}));
    // R13: every strobe follows a frame accepted on the previous edge
    a_r13_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || rst_req || wake_clr) |-> ($past(frm_valid) && !$past(in_reset)));
endmodule

// File: tb/cmdg_top_test.sv
module cmdg_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_reset = 1'b0;
    logic            in_diag = 1'b0;
    logic            frm_valid = 1'b0;
    logic [7:0]      frm_cmd = '0;
    logic [7:0]      frm_data = '0;
    logic [7:0][7:0] rf_m;
    logic            reg_we, rst_req, wake_clr, auto_start_dis;
    logic [2:0]      reg_idx;
    logic [7:0]      reg_wdata, reg_wmask, rd_data;
    int              total = 0;
    int              bad = 0;
    logic            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdg_top uut (
        .clk(clk), .rst_n(rst_n), .in_reset(in_reset), .in_diag(in_diag),
        .frm_valid(frm_valid), .frm_cmd(frm_cmd), .frm_data(frm_data),
        .rf_val(rf_m), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .rd_data(rd_data),
        .rst_req(rst_req), .wake_clr(wake_clr), .auto_start_dis(auto_start_dis)
    );

    // register-file model: index 7 holds a fixed identifier
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_m    <= '0;
            rf_m[7] <= 8'h5C;
        end else if (reg_we) begin
            rf_m[reg_idx] <= (rf_m[reg_idx] & ~reg_wmask) | (reg_wdata & reg_wmask);
        end
    end

    // {diag, cmd, data, expect write, expect read byte}
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 8'h02, 8'h00, 1'b0, 8'h5C}, {1'b0, 8'h58, 8'h00, 1'b0, 8'h00},
        {1'b1, 8'hFB, 8'h3C, 1'b1, 8'h00}, {1'b0, 8'h0B, 8'h00, 1'b0, 8'h3C},
        {1'b0, 8'hFD, 8'h11, 1'b0, 8'h00}, {1'b0, 8'h0D, 8'h00, 1'b0, 8'h00},
        {1'b0, 8'h58, 8'h00, 1'b0, 8'h10}, {1'b1, 8'hC4, 8'h55, 1'b0, 8'h00},
        {1'b1, 8'hFB, 8'h77, 1'b0, 8'h00}, {1'b0, 8'h0B, 8'h00, 1'b0, 8'h3C},
        {1'b0, 8'h58, 8'h00, 1'b0, 8'h14}, {1'b1, 8'hC7, 8'hAA, 1'b0, 8'h00},
        {1'b1, 8'hA4, 8'hFF, 1'b1, 8'h00}, {1'b0, 8'h52, 8'h00, 1'b0, 8'h0F},
        {1'b0, 8'hC1, 8'h55, 1'b0, 8'h00}, {1'b0, 8'hD8, 8'h99, 1'b0, 8'h00},
        {1'b0, 8'h28, 8'h00, 1'b0, 8'h00}, {1'b0, 8'hC2, 8'hAA, 1'b0, 8'h00},
        {1'b0, 8'hD8, 8'h99, 1'b1, 8'h00}, {1'b0, 8'h28, 8'h00, 1'b0, 8'h99},
        {1'b0, 8'hF1, 8'h55, 1'b0, 8'h00}, {1'b0, 8'h58, 8'h00, 1'b0, 8'h12},
        {1'b0, 8'hAB, 8'h42, 1'b1, 8'h00}, {1'b0, 8'h5B, 8'h00, 1'b0, 8'h42},
        {1'b0, 8'hC4, 8'h55, 1'b0, 8'h00}, {1'b0, 8'hC1, 8'h55, 1'b0, 8'h00},
        {1'b0, 8'hAD, 8'h24, 1'b1, 8'h00}, {1'b0, 8'h5D, 8'h00, 1'b0, 8'h24},
        {1'b0, 8'h58, 8'h00, 1'b0, 8'h17}, {1'b0, 8'hF7, 8'hAA, 1'b0, 8'h00},
        {1'b0, 8'h58, 8'h00, 1'b0, 8'h1F}, {1'b0, 8'hF4, 8'h55, 1'b0, 8'h00},
        {1'b0, 8'h58, 8'h00, 1'b0, 8'h17}, {1'b0, 8'hC2, 8'h55, 1'b0, 8'h00},
        {1'b0, 8'h58, 8'h00, 1'b0, 8'h37}, {1'b0, 8'h99, 8'h00, 1'b0, 8'h00},
        {1'b0, 8'hF2, 8'hAA, 1'b0, 8'h00}, {1'b0, 8'h58, 8'h00, 1'b0, 8'h35},
        {1'b0, 8'hDD, 8'h01, 1'b0, 8'h00}, {1'b0, 8'h2D, 8'h00, 1'b0, 8'h00}
    };
    localparam string TAG [NV] = '{
        "R12", "R3", "R4", "R4", "R4", "R8", "R8", "R2", "R4", "R8",
        "R2", "R2", "R7", "R7", "R2", "R5", "R5", "R2", "R5", "R5",
        "R2", "R3", "R6", "R6", "R2", "R2", "R6", "R6", "R3", "R10",
        "R10", "R10", "R10", "R11", "R11", "R12", "R2", "R2", "R5", "R5"
    };

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic frame(input logic [7:0] c, input logic [7:0] d);
        @(negedge clk);
        frm_valid = 1'b1;
        frm_cmd   = c;
        frm_data  = d;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 state under reset
        check("R1", "rd_data", rd_data, 8'h00);
        check("R1", "strobes", {5'b0, reg_we, rst_req, wake_clr}, 8'h00);
        check("R1", "auto_start_dis", {7'b0, auto_start_dis}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            in_diag = VEC[i][25];
            frame(VEC[i][24:17], VEC[i][16:9]);
            check(TAG[i], $sformatf("vec %0d write strobe", i), {7'b0, reg_we}, {7'b0, VEC[i][8]});
            check(TAG[i], $sformatf("vec %0d rd_data", i), rd_data, VEC[i][7:0]);
        end

        // R7 sub-field write port contents
        in_diag = 1'b1;
        frame(8'hC7, 8'hAA);
        frame(8'hA4, 8'h35);
        check("R7", "we", {7'b0, reg_we}, 8'h01);
        check("R7", "idx", {5'b0, reg_idx}, 8'h06);
        check("R7", "mask", reg_wmask, 8'h0F);
        check("R7", "wdata", reg_wdata, 8'h35);
        in_diag = 1'b0;
        frame(8'h52, 8'h00);
        check("R7", "field readback", rd_data, 8'h05);
        @(negedge clk);
        check("R13", "rd_data hold", rd_data, 8'h05);

        // R9 pulses, R13 one cycle wide
        frame(8'hF8, 8'h5A);
        check("R9", "rst_req", {7'b0, rst_req}, 8'h01);
        @(negedge clk);
        check("R13", "rst_req width", {7'b0, rst_req}, 8'h00);
        frame(8'hF8, 8'h00);
        check("R11", "rst_req bad key", {7'b0, rst_req}, 8'h00);
        frame(8'hDE, 8'h8E);
        check("R9", "wake_clr", {7'b0, wake_clr}, 8'h01);
        frame(8'hDE, 8'h55);
        check("R11", "wake_clr bad key", {7'b0, wake_clr}, 8'h00);
        frame(8'hF7, 8'hAA);
        check("R10", "auto_start_dis pin", {7'b0, auto_start_dis}, 8'h01);

        // R1 device reset with a frame that must be ignored
        @(negedge clk);
        in_reset  = 1'b1;
        in_diag   = 1'b1;
        frm_valid = 1'b1;
        frm_cmd   = 8'hFB;
        frm_data  = 8'h55;
        @(negedge clk);
        in_reset  = 1'b0;
        frm_valid = 1'b0;
        in_diag   = 1'b0;
        check("R1", "we during reset", {7'b0, reg_we}, 8'h00);
        check("R1", "auto_start_dis cleared", {7'b0, auto_start_dis}, 8'h00);
        frame(8'h58, 8'h00);
        check("R1", "status after reset", rd_data, 8'h00);
        frame(8'h0B, 8'h00);
        check("R1", "ignored frame", rd_data, 8'h3C);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule